// File: doc/BRIEF.md
# Synchronous Byte Shifter (Transmit Side)

This block sends one byte at a time over a two-wire synchronous link: one data line and one shift-clock line. The host writes a byte with a single-cycle strobe. After a fixed start latency of one machine cycle, the block drives the byte out least significant bit first. Each bit is held for one full period of a shift clock that runs at half the system clock rate. A receiver on the other end samples the data line on each rising edge of the shift clock.

The end of a transfer is found without a bit counter. A write loads the byte into a shift register one bit wider than the data and puts a '1' marker in the extra top position. Each shift moves the register right and brings a '0' in at the top. The transfer is complete when the marker sits directly above the last data bit and nothing but zeros lies above it. The block then makes one final shift, returns both lines to their idle level and raises a done flag. The flag stays set until the host clears it.

Top module: `sync_shift_tx`

## Requirements
- R1: Outside a transfer, `txd_o` and `sclk_o` are both 1. After reset the block is idle and `done_o` is 0.
- R2: A write (`wr_i` high for one clock) accepted while idle sends the 8 bits of `wdata_i` on `txd_o`, bit 0 first and bit 7 last. Each bit is steady across one rising edge of `sclk_o`.
- R3: During a transfer, `sclk_o` is 0 for one system clock and then 1 for one system clock, repeating. Its period is therefore two system clocks.
- R4: The first low phase of `sclk_o` starts exactly `MC_CLKS` system clocks (default 12) after the clock edge that samples the write.
- R5: `txd_o` changes only where `sclk_o` falls. Each falling edge moves the next bit onto the line.
- R6: A transfer has exactly 8 rising edges of `sclk_o`, which is 16 system clocks of shifting. At the edge that ends the eighth high phase, `sclk_o` and `txd_o` return to 1 and `done_o` becomes 1 at the same edge.
- R7: `done_o` stays 1 until `done_clr_i` is sampled high. If the end of a transfer and a clear fall on the same edge, `done_o` ends up 1.
- R8: A write that arrives while the block is waiting to start or is shifting has no effect on the byte being sent or on its timing.
- R9: A write accepted while `done_o` is already 1 starts a normal transfer and leaves `done_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_i | input | 1 | Host write strobe, one clock wide |
| wdata_i | input | 8 | Byte to transmit, sampled with `wr_i` |
| done_clr_i | input | 1 | Clears the done flag |
| txd_o | output | 1 | Serial data line, LSB first |
| sclk_o | output | 1 | Shift clock, idle high |
| done_o | output | 1 | Sticky transfer-complete flag |

## Verification
The assertions assume that `wr_i` and `done_clr_i` are synchronous to `clk_i`. They also assume the reset input is held low long enough for the internal synchronizer to settle before any write. The stimulus drives every input on the falling system-clock edge and waits several clocks after reset before the first strobe. Writes during a transfer are placed on purpose both in the start wait and in the shifting phase. A clear is held across the final edge of one transfer, so the set-over-clear priority is reached.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } stx_state_e;
endpackage

// File: rtl/stx_rst_sync.sv
module stx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/stx_start_delay.sv
module stx_start_delay #(
  parameter int unsigned MC_CLKS = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic pend_o,
  output logic fire_o
);
  localparam int unsigned CW = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(MC_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          cnt_en;

  assign fire_o = pend_q && (cnt_q == '0);
  assign pend_o = pend_q;
  assign cnt_en = arm_i || pend_q;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (pend_q) begin
      if (cnt_q == '0) pend_d = 1'b0;
      else             cnt_d  = cnt_q - CW'(1);
    end else if (arm_i) begin
      pend_d = 1'b1;
      cnt_d  = RELOAD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // R4: the wait steps down by one each clock until it expires
  p_countdown_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q != '0) |=> (pend_q && cnt_q == $past(cnt_q) - CW'(1)));

  // R8: a new arm during a pending wait does not restart it
  p_rearm_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && arm_i && cnt_q != '0) |=> (cnt_q != RELOAD || RELOAD == '0));
endmodule

// File: rtl/stx_marker_shreg.sv
module stx_marker_shreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_i,
  output logic          bit0_o,
  output logic          last_o
);
  localparam int unsigned SW = DW + 1;

  logic [SW-1:0] sh_q, sh_d;
  logic          sh_en;

  assign sh_en  = load_i || shift_i;
  assign bit0_o = sh_q[0];
  // marker directly above the final data bit, zeros above it
  assign last_o = (sh_q[SW-1:2] == '0) && sh_q[1];

  always_comb begin
    sh_d = sh_q;
    if (load_i)       sh_d = {1'b1, data_i};
    else if (shift_i) sh_d = {1'b0, sh_q[SW-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  // R5: a falling shift clock moves the register right with zero fill
  p_shift_right_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (sh_q == {1'b0, $past(sh_q[SW-1:1])}));

  // R2: a load places the marker above the byte
  p_load_marker_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sh_q[SW-1] && sh_q[DW-1:0] == $past(data_i)));
endmodule

// File: rtl/sync_shift_tx.sv
module sync_shift_tx
  import stx_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned MC_CLKS = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_clr_i,
  output logic          txd_o,
  output logic          sclk_o,
  output logic          done_o
);
  logic       rst_n;
  stx_state_e state_q, state_d;
  logic       ph_q, ph_d;
  logic       done_q, done_d;
  logic       arm, fire, pend, shift, bit0, last, finish;

  stx_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  assign arm    = (state_q == ST_IDLE) && wr_i;
  assign shift  = (state_q == ST_SHIFT) && ph_q;
  assign finish = shift && last;

  stx_start_delay #(.MC_CLKS(MC_CLKS)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .arm_i (arm),
    .pend_o(pend),
    .fire_o(fire)
  );

  stx_marker_shreg #(.DW(DW)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (arm),
    .data_i (wdata_i),
    .shift_i(shift),
    .bit0_o (bit0),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    unique case (state_q)
      ST_IDLE:  if (arm) state_d = ST_WAIT;
      ST_WAIT: begin
        if (fire) begin
          state_d = ST_SHIFT;
          ph_d    = 1'b0;
        end
      end
      ST_SHIFT: begin
        ph_d = ~ph_q;
        if (finish) state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d = done_q;
    if (done_clr_i) done_d = 1'b0;
    if (finish)     done_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      done_q  <= done_d;
    end
  end

  assign sclk_o = (state_q == ST_SHIFT) ? ph_q : 1'b1;
  assign txd_o  = (state_q == ST_SHIFT) ? bit0 : 1'b1;
  assign done_o = done_q;

  // R1: both lines rest high outside a transfer
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q != ST_SHIFT) |-> (txd_o && sclk_o));

  // R3: shift clock alternates on every system clock while shifting
  p_sclk_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_SHIFT && $past(state_q == ST_SHIFT)) |-> (sclk_o != $past(sclk_o)));

  // R6: the final shift ends the transfer and raises done
  p_end_sets_done_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    finish |=> (state_q == ST_IDLE && done_o && sclk_o));

  // R7: done holds until cleared
  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_q && !done_clr_i) |=> done_q);

  // R4: the start wait and the idle state never overlap
  p_wait_matches_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> pend);

  // R8: a write while busy leaves the state sequence untouched
  p_busy_write_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_SHIFT && wr_i && !finish) |=> (state_q == ST_SHIFT));
endmodule

// File: tb/sync_shift_tx_tb_top.sv
module sync_shift_tx_tb_top;
  localparam int MC = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_i;
  logic [7:0] wdata_i;
  logic       done_clr_i;
  logic       txd_o, sclk_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit cap_en = 1'b0;
  bit finished = 1'b0;
  bit cap_q[$];

  // behavioural reference state
  int       m_state;   // 0 idle, 1 waiting, 2 shifting
  int       m_wait;
  int       m_half;
  bit [7:0] m_byte;
  bit       m_done;

  always #2.5 clk_i = ~clk_i;

  sync_shift_tx #(.DW(8), .MC_CLKS(MC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .done_clr_i(done_clr_i), .txd_o(txd_o), .sclk_o(sclk_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_state = 0; m_wait = 0; m_half = 0; m_byte = '0; m_done = 1'b0;
    end else begin
      bit set_done;
      set_done = 1'b0;
      case (m_state)
        0: if (wr_i) begin m_state = 1; m_wait = 0; m_byte = wdata_i; end
        1: begin
          m_wait++;
          if (m_wait == MC) begin m_state = 2; m_half = 0; end
        end
        default: begin
          m_half++;
          if (m_half == 16) begin m_state = 0; set_done = 1'b1; end
        end
      endcase
      if (done_clr_i) m_done = 1'b0;
      if (set_done)   m_done = 1'b1;
    end
  end

  function automatic bit exp_sclk();
    return (m_state == 2) ? bit'(m_half % 2) : 1'b1;
  endfunction
  function automatic bit exp_txd();
    return (m_state == 2) ? m_byte[m_half / 2] : 1'b1;
  endfunction

  // cycle-by-cycle comparison against the reference
  always @(negedge clk_i) begin
    cycles++;
    if (rst_ni && cap_en && !finished) begin
      chk(txd_o == exp_txd(), "R2 R5 txd", int'(txd_o), int'(exp_txd()));
      chk(sclk_o == exp_sclk(), "R3 sclk", int'(sclk_o), int'(exp_sclk()));
      chk(done_o == m_done, "R7 done", int'(done_o), int'(m_done));
    end
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", cycles, 100000);
      report();
    end
  end

  // receiver model: sample data on each rising shift clock
  always @(posedge sclk_o) if (cap_en) cap_q.push_back(txd_o);

  task automatic send(input bit [7:0] b, input bit inject, input bit hold_clr);
    int lat;
    bit [7:0] got;
    cap_q.delete();
    wr_i = 1'b1; wdata_i = b;
    if (hold_clr) done_clr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = ~b;
    lat = 1;
    while (sclk_o !== 1'b0 && lat < 100) begin
      if (inject && lat == 3) wr_i = 1'b1;
      if (inject && lat == 4) wr_i = 1'b0;
      @(negedge clk_i);
      lat++;
    end
    // the write edge precedes the first negedge, so low shows at MC+1
    chk(lat == MC + 1, "R4 start latency", lat, MC + 1);
    for (int i = 0; i < 16; i++) begin
      if (inject && i == 5) wr_i = 1'b1;
      if (inject && i == 6) wr_i = 1'b0;
      @(negedge clk_i);
    end
    if (hold_clr) begin
      chk(done_o == 1'b1, "R7 set beats clear", int'(done_o), 1);
      done_clr_i = 1'b0;
    end
    chk(sclk_o && txd_o, "R6 lines idle at end", int'({sclk_o, txd_o}), 3);
    chk(done_o == 1'b1, "R6 done at end", int'(done_o), 1);
    chk(cap_q.size() == 8, "R6 rising edge count", cap_q.size(), 8);
    got = '0;
    foreach (cap_q[k]) if (k < 8) got[k] = cap_q[k];
    chk(got == b, inject ? "R8 byte after busy writes" : "R2 byte LSB first",
        int'(got), int'(b));
  endtask

  task automatic clear_done();
    done_clr_i = 1'b1;
    @(negedge clk_i);
    done_clr_i = 1'b0;
    chk(done_o == 1'b0, "R7 cleared", int'(done_o), 0);
  endtask

  initial begin
    rst_ni = 1'b0; wr_i = 1'b0; wdata_i = '0; done_clr_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    cap_en = 1'b1;
    chk(txd_o && sclk_o, "R1 idle lines", int'({txd_o, sclk_o}), 3);
    chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);

    send(8'hA5, 1'b0, 1'b0);
    repeat (5) @(negedge clk_i);
    chk(done_o == 1'b1, "R7 sticky", int'(done_o), 1);
    chk(txd_o && sclk_o, "R1 idle after transfer", int'({txd_o, sclk_o}), 3);
    clear_done();

    send(8'h01, 1'b0, 1'b0); clear_done();
    send(8'h80, 1'b0, 1'b0); clear_done();
    send(8'hFF, 1'b0, 1'b0); clear_done();
    send(8'h00, 1'b0, 1'b0); clear_done();

    send(8'h3C, 1'b1, 1'b0);
    // R9: write while done is still set
    repeat (2) @(negedge clk_i);
    wr_i = 1'b1; wdata_i = 8'h5A;
    @(negedge clk_i);
    wr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(done_o == 1'b1, "R9 done kept on new write", int'(done_o), 1);
    repeat (40) @(negedge clk_i);
    chk(done_o == 1'b1, "R9 done after second transfer", int'(done_o), 1);
    clear_done();

    send(8'hC6, 1'b0, 1'b1);
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b1, "R7 stays after priority case", int'(done_o), 1);
    clear_done();

    repeat (4) @(negedge clk_i);
    finished = 1'b1;
    report();
  end
endmodule